// File: doc/BRIEF.md
# Serial Shift Slice with Shadow Exchange

This block is one lane of a programmable serial I/O engine. A 32-bit data register either drives its least significant bit onto a serial output pin, or, in capture mode, takes a bit from the serial input pin at its top end. The register moves one place toward bit 0 on every slice tick. A per-slice pre-divider, optionally gated by an active-low qualifier pin, produces these ticks from the system clock.

A frame counter counts ticks. When a frame ends, the data register and a shadow register trade contents, so a bus master can refill the shadow while the next frame shifts. Each exchange raises a one-cycle request strobe for a DMA channel, and an interrupt strobe when that is enabled.

In recirculating mode the bit leaving bit 0 re-enters at the top. The stored pattern then sets the request rate: one strobe for every 1 bit that passes bit 0. A single-shot mode stops the slice by itself at the end of one frame.

Top module: `shift_slice`

## Requirements
- R1: After synchronous reset, ser_out, req and irq are 0 and ser_oe is 1.
  - The reset state is: control cleared, data and shadow 0, divider 1, tick counter 0, frame reload 31.
- R2: In output mode, ser_out always equals data bit 0. On each tick the register moves one place toward bit 0, so a word leaves LSB first, and a 0 enters at bit 31.
- R3: A frame holds FRAME+1 ticks, with FRAME written at address 3 in bits 7:0. On a frame's last tick the data register takes the shadow value, and the shadow takes the data value as shifted by that tick. The counter then reloads, so the next frame follows with no gap.
- R4: req is high for exactly the one cycle after the edge that ends a frame. irq equals req whenever control bit 5 is set, and is 0 otherwise.
- R5: A divider value N, written at address 4 in bits 11:0, gives one tick every N running cycles. N of 0 or 1 gives a tick every cycle. Writing the divider clears the tick counter.
- R6: Writing P at address 5 loads the tick counter. The first tick then falls on the (P+1)th running cycle, which sets the slice phase in steps of one clock.
- R7: With control bit 1 set, the bit leaving bit 0 re-enters at bit 31. No exchange occurs. req pulses once for each tick that shifts out a 1.
- R8: With control bit 2 set, control bit 0 (run) clears itself at the end of one frame. Shifting resumes only after a new control write at address 0.
- R9: With control bit 4 set and qual_n high, the divider, frame counter and data register hold still.
- R10: With control bit 3 set, ser_oe is 0 and ser_in enters at bit 31 on each tick. A full 32-tick frame therefore places the first captured bit at bit 0 of the word that is moved to the shadow.
- R11: Register writes override the slice in the same cycle.
  - A write to the shadow (address 2) in the cycle of an exchange leaves the written value in the shadow, while the data register still takes the old shadow.
  - A write to data (address 1) overrides shifting and exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 control, 1 data, 2 shadow, 3 frame, 4 divider, 5 phase |
| wr_data | input | 32 | Write value; control bits are run, recirculate, single-shot, capture, gate, irq enable (bit 0 upward) |
| ser_in | input | 1 | Serial data input in capture mode |
| qual_n | input | 1 | Active-low qualifier that gates ticks when gating is enabled |
| ser_out | output | 1 | Serial data output, equal to data bit 0 |
| ser_oe | output | 1 | Output enable, low in capture mode |
| req | output | 1 | One-cycle request strobe |
| irq | output | 1 | One-cycle interrupt strobe |

## Verification
Some properties are checked on every cycle by assertions:
- ticks cannot come back to back unless the divider is 1;
- a non-exchanging tick moves the register down one place;
- an exchange loads the shadow value;
- the frame counter never exceeds its reload;
- a gated slice holds its data;
- every req follows a tick;
- single-shot clears run.

Only the bench scenarios show the cases that need a sequence:
- the rate of requests set by a recirculating pattern and divider;
- the phase offset from a counter preset;
- a full capture frame returning through the shadow;
- a shadow write colliding with an exchange.

// File: rtl/slice_pkg.sv
package slice_pkg;

    typedef struct packed {
        logic irq_en;
        logic gate;
        logic capture;
        logic single;
        logic loop;
        logic run;
    } slice_ctrl_t;

    localparam int CTRL_W = $bits(slice_ctrl_t);

    typedef enum logic [2:0] {
        A_CTRL   = 3'd0,
        A_DATA   = 3'd1,
        A_SHADOW = 3'd2,
        A_FRAME  = 3'd3,
        A_DIV    = 3'd4,
        A_PHASE  = 3'd5
    } slice_addr_e;

    // bit that enters the top of the register on a tick
    function automatic logic fill_bit(input logic loop, input logic capture,
                                      input logic lsb, input logic pin);
        if (loop)
            return lsb;
        return capture & pin;
    endfunction

endpackage

// File: rtl/slice_prediv.sv
module slice_prediv #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             ld_div,
    input  logic             ld_phase,
    input  logic [DIV_W-1:0] div_val,
    input  logic [DIV_W-1:0] phase_val,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] reload;
    logic             past_ok;

    assign reload = (div_val == '0) ? '0 : div_val - DIV_W'(1);
    assign tick   = adv && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ld_phase) begin
            cnt_q <= phase_val;
        end else if (ld_div) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= (cnt_q == '0) ? reload : cnt_q - DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    AST_DIV_GAP: assert property (@(posedge clk) disable iff (rst)
        (past_ok && tick && $past(tick) && !$past(ld_div) && !$past(ld_phase))
            |-> ($past(div_val) <= DIV_W'(1))); // R5

endmodule

// File: rtl/slice_poscnt.sv
module slice_poscnt #(
    parameter int POS_W      = 8,
    parameter int RESET_LAST = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             ld,
    input  logic [POS_W-1:0] ld_val,
    output logic             last
);
    logic [POS_W-1:0] reload_q;
    logic [POS_W-1:0] pos_q;

    assign last = tick && (pos_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= POS_W'(RESET_LAST);
            pos_q    <= POS_W'(RESET_LAST);
        end else if (ld) begin
            reload_q <= ld_val;
            pos_q    <= ld_val;
        end else if (last) begin
            pos_q    <= reload_q;
        end else if (tick) begin
            pos_q    <= pos_q - POS_W'(1);
        end
    end

    AST_POS_BOUND: assert property (@(posedge clk) disable iff (rst)
        pos_q <= reload_q); // R3

endmodule

// File: rtl/slice_shreg.sv
module slice_shreg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              swap,
    input  logic              fill,
    input  logic              ld_data,
    input  logic              ld_shadow,
    input  logic [DATA_W-1:0] wval,
    output logic [DATA_W-1:0] data_q
);
    logic [DATA_W-1:0] shadow_q;
    logic [DATA_W-1:0] shifted;
    logic              past_ok;

    assign shifted = {fill, data_q[DATA_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q   <= '0;
            shadow_q <= '0;
        end else begin
            if (ld_data)      data_q <= wval;
            else if (swap)    data_q <= shadow_q;
            else if (tick)    data_q <= shifted;

            if (ld_shadow)    shadow_q <= wval;
            else if (swap)    shadow_q <= shifted;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    AST_SWAP_LOADS: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(swap && !ld_data)) |-> (data_q == $past(shadow_q))); // R3

    AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(tick && !swap && !ld_data))
            |-> (data_q[DATA_W-2:0] == $past(data_q[DATA_W-1:1]))); // R2

endmodule

// File: rtl/shift_slice.sv
module shift_slice
    import slice_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int POS_W  = 8,
    parameter int DIV_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ser_in,
    input  logic              qual_n,
    output logic              ser_out,
    output logic              ser_oe,
    output logic              req,
    output logic              irq
);
    localparam int LAST_BIT = DATA_W - 1;

    slice_ctrl_t       ctrl_q;
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] data_q;
    logic              hit_ctrl, hit_data, hit_shadow, hit_frame, hit_div, hit_phase;
    logic              adv, tick, last, swap, fill, req_d;
    logic              req_q, irq_q, past_ok;

    assign hit_ctrl   = wr_en && (wr_addr == A_CTRL);
    assign hit_data   = wr_en && (wr_addr == A_DATA);
    assign hit_shadow = wr_en && (wr_addr == A_SHADOW);
    assign hit_frame  = wr_en && (wr_addr == A_FRAME);
    assign hit_div    = wr_en && (wr_addr == A_DIV);
    assign hit_phase  = wr_en && (wr_addr == A_PHASE);

    assign adv  = ctrl_q.run && (!ctrl_q.gate || !qual_n);
    assign fill = fill_bit(ctrl_q.loop, ctrl_q.capture, data_q[0], ser_in);
    assign swap = last && !ctrl_q.loop;
    assign req_d = ctrl_q.loop ? (tick && data_q[0]) : swap;

    slice_prediv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst(rst), .adv(adv), .ld_div(hit_div), .ld_phase(hit_phase),
        .div_val(div_q), .phase_val(wr_data[DIV_W-1:0]), .tick(tick)
    );

    slice_poscnt #(.POS_W(POS_W), .RESET_LAST(LAST_BIT)) u_pos (
        .clk(clk), .rst(rst), .tick(tick), .ld(hit_frame),
        .ld_val(wr_data[POS_W-1:0]), .last(last)
    );

    slice_shreg #(.DATA_W(DATA_W)) u_sr (
        .clk(clk), .rst(rst), .tick(tick), .swap(swap), .fill(fill),
        .ld_data(hit_data), .ld_shadow(hit_shadow), .wval(wr_data), .data_q(data_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            div_q   <= DIV_W'(1);
            req_q   <= 1'b0;
            irq_q   <= 1'b0;
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            if (hit_ctrl)
                ctrl_q <= slice_ctrl_t'(wr_data[CTRL_W-1:0]);
            else if (last && ctrl_q.single)
                ctrl_q.run <= 1'b0;
            if (hit_div)
                div_q <= wr_data[DIV_W-1:0];
            req_q <= req_d;
            irq_q <= req_d && ctrl_q.irq_en;
        end
    end

    assign ser_out = data_q[0];
    assign ser_oe  = !ctrl_q.capture;
    assign req     = req_q;
    assign irq     = irq_q;

    AST_REQ_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        (past_ok && req_q) |-> $past(tick)); // R4

    AST_SINGLE_STOP: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(last && ctrl_q.single && !hit_ctrl)) |-> !ctrl_q.run); // R8

    AST_GATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(ctrl_q.gate && qual_n && !wr_en)) |-> $stable(data_q)); // R9

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        (past_ok && irq_q) |-> req_q); // R4

endmodule

// File: tb/shift_slice_test.sv
`timescale 1ns/1ps
module shift_slice_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = 3'd0;
    logic [31:0] wr_data = 32'd0;
    logic        ser_in = 1'b0;
    logic        qual_n = 1'b0;
    logic        ser_out, ser_oe, req, irq;

    int    vec = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string tag = "R1";

    logic [31:0] m_data, m_sh;
    logic [5:0]  m_ctrl;
    logic [7:0]  m_frame, m_pos;
    logic [11:0] m_div, m_cnt;
    logic        m_req, m_irq;

    always #2 clk = ~clk;

    shift_slice uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ser_in(ser_in), .qual_n(qual_n), .ser_out(ser_out), .ser_oe(ser_oe),
        .req(req), .irq(irq)
    );

    task automatic chk(input bit ok, input string t, input int act, input int exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual %0h expected %0h", t, act, exp);
        end
    endtask

    // one clock: reference state from the requirements, then compare at negedge
    task automatic step();
        logic [31:0] nd, ns, shf;
        logic [5:0]  nc;
        logic [7:0]  nf, np;
        logic [11:0] ndv, ncn, dm1;
        logic        adv, tk, lst, swp, fb, nrq, nir;
        logic [3:0]  exp_o, act_o;
        if (rst) begin
            nd = 0; ns = 0; nc = 0; nf = 8'd31; np = 8'd31; ndv = 12'd1; ncn = 0;
            nrq = 0; nir = 0;
        end else begin
            adv = m_ctrl[0] && (!m_ctrl[4] || !qual_n);
            tk  = adv && (m_cnt == 0);
            dm1 = (m_div == 0) ? 12'd0 : m_div - 12'd1;
            fb  = m_ctrl[1] ? m_data[0] : (m_ctrl[3] ? ser_in : 1'b0);
            shf = {fb, m_data[31:1]};
            lst = tk && (m_pos == 0);
            swp = lst && !m_ctrl[1];
            nd  = (wr_en && wr_addr == 1) ? wr_data : swp ? m_sh : tk ? shf : m_data;
            ns  = (wr_en && wr_addr == 2) ? wr_data : swp ? shf : m_sh;
            nf  = (wr_en && wr_addr == 3) ? wr_data[7:0] : m_frame;
            np  = (wr_en && wr_addr == 3) ? wr_data[7:0] : lst ? m_frame : tk ? m_pos - 8'd1 : m_pos;
            nc  = (wr_en && wr_addr == 0) ? wr_data[5:0] : (lst && m_ctrl[2]) ? (m_ctrl & 6'h3e) : m_ctrl;
            ndv = (wr_en && wr_addr == 4) ? wr_data[11:0] : m_div;
            ncn = (wr_en && wr_addr == 5) ? wr_data[11:0] : (wr_en && wr_addr == 4) ? 12'd0 :
                  adv ? ((m_cnt == 0) ? dm1 : m_cnt - 12'd1) : m_cnt;
            nrq = m_ctrl[1] ? (tk && m_data[0]) : swp;
            nir = nrq && m_ctrl[5];
        end
        @(posedge clk);
        @(negedge clk);
        m_data = nd; m_sh = ns; m_ctrl = nc; m_frame = nf; m_pos = np;
        m_div = ndv; m_cnt = ncn; m_req = nrq; m_irq = nir;
        exp_o = {m_data[0], ~m_ctrl[3], m_req, m_irq};
        act_o = {ser_out, ser_oe, req, irq};
        chk(act_o === exp_o, tag, int'(act_o), int'(exp_o));
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        step();
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; qual_n = 1'b0; ser_in = 1'b0;
        repeat (2) step();
        rst = 1'b0;
    endtask

    function automatic int count_bit(input logic b);
        return b ? 1 : 0;
    endfunction

    initial begin
        int n;
        void'($urandom(32'd20240611));

        // R1 reset state
        tag = "R1";
        do_reset();
        chk(ser_out == 1'b0 && req == 1'b0 && irq == 1'b0, "R1 outputs", {ser_out, req, irq}, 0);
        chk(ser_oe == 1'b1, "R1 oe", ser_oe, 1);

        // R2 LSB-first output
        tag = "R2";
        wr(3'd1, 32'h0000_00B5);
        wr(3'd0, 32'h1);
        for (int i = 0; i < 8; i++) begin
            chk(ser_out == ((32'hB5 >> i) & 1), "R2 serial bit", ser_out, (32'hB5 >> i) & 1);
            step();
        end
        repeat (30) step();

        // R3/R4 exchange every FRAME+1 ticks, one-cycle strobes with irq enabled
        tag = "R3";
        do_reset();
        wr(3'd3, 32'd3);
        wr(3'd1, 32'h0000_000A);
        wr(3'd2, 32'h0000_0005);
        wr(3'd0, 32'h21);
        n = 0;
        for (int i = 0; i < 40; i++) begin
            bit prev;
            prev = req;
            step();
            n += count_bit(req);
            if (req && prev) chk(1'b0, "R4 strobe width", 2, 1);
        end
        chk(n == 10, "R3 exchange count", n, 10);
        tag = "R4";
        wr(3'd0, 32'h01);
        repeat (12) step();

        // R5 divider with recirculating 0xAAAAAAAA: one request every 22 clocks
        tag = "R5";
        do_reset();
        wr(3'd1, 32'hAAAA_AAAA);
        wr(3'd4, 32'd11);
        wr(3'd0, 32'h03);
        n = 0;
        for (int i = 0; i < 220; i++) begin step(); n += count_bit(req); end
        chk(n == 10, "R5 request rate", n, 10);
        wr(3'd4, 32'd0);
        repeat (10) step();

        // R7 recirculating 0x80000000: one request per 32 ticks
        tag = "R7";
        do_reset();
        wr(3'd1, 32'h8000_0000);
        wr(3'd0, 32'h03);
        n = 0;
        for (int i = 0; i < 64; i++) begin step(); n += count_bit(req); end
        chk(n == 2, "R7 pattern requests", n, 2);

        // R6 phase preset
        tag = "R6";
        do_reset();
        wr(3'd1, 32'h0000_0001);
        wr(3'd4, 32'd4);
        wr(3'd5, 32'd2);
        wr(3'd0, 32'h01);
        step(); chk(ser_out == 1'b1, "R6 before tick", ser_out, 1);
        step(); chk(ser_out == 1'b1, "R6 before tick", ser_out, 1);
        step(); chk(ser_out == 1'b0, "R6 first tick", ser_out, 0);
        repeat (20) step();

        // R8 single shot
        tag = "R8";
        do_reset();
        wr(3'd3, 32'd7);
        wr(3'd1, 32'h0000_0055);
        wr(3'd2, 32'h0000_0003);
        wr(3'd0, 32'h05);
        n = 0;
        for (int i = 0; i < 40; i++) begin step(); n += count_bit(req); end
        chk(n == 1, "R8 one frame", n, 1);
        wr(3'd0, 32'h05);
        repeat (12) step();

        // R9 qualifier gating
        tag = "R9";
        do_reset();
        wr(3'd1, 32'h0000_0001);
        wr(3'd0, 32'h11);
        qual_n = 1'b1;
        repeat (20) step();
        chk(ser_out == 1'b1 && req == 1'b0, "R9 held while gated", ser_out, 1);
        qual_n = 1'b0;
        step();
        chk(ser_out == 1'b0, "R9 resumes", ser_out, 0);

        // R10 capture a word, return it through the shadow to the pin
        tag = "R10";
        do_reset();
        wr(3'd0, 32'h09);
        chk(ser_oe == 1'b0, "R10 oe low", ser_oe, 0);
        for (int i = 0; i < 32; i++) begin
            ser_in = (32'h1234_5678 >> i) & 1;
            step();
        end
        wr(3'd0, 32'h01);
        repeat (31) step();
        for (int i = 0; i < 32; i++) begin
            chk(ser_out == ((32'h1234_5678 >> i) & 1), "R10 captured bit", ser_out,
                (32'h1234_5678 >> i) & 1);
            step();
        end

        // R11 shadow write in the exchange cycle
        tag = "R11";
        do_reset();
        wr(3'd3, 32'd3);
        wr(3'd1, 32'h0000_0000);
        wr(3'd2, 32'h0000_0009);
        wr(3'd0, 32'h01);
        repeat (3) step();
        wr(3'd2, 32'h0000_0006);
        chk(ser_out == 1'b1, "R11 data took old shadow", ser_out, 1);
        repeat (4) step();
        chk(ser_out == 1'b0, "R11 written shadow arrives", ser_out, 0);
        step();
        chk(ser_out == 1'b1, "R11 written shadow bit1", ser_out, 1);

        // random mix against the reference model (R2 R3 R5 R7 R8 R9 R10 R11)
        tag = "R3 random";
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            int r;
            qual_n = ($urandom % 4) == 0;
            ser_in = $urandom % 2;
            r = $urandom % 8;
            if (r == 0) begin
                logic [2:0] a;
                logic [31:0] v;
                a = 3'($urandom % 6);
                case (a)
                    3'd0:    v = ($urandom % 64) | 32'h1;
                    3'd3:    v = $urandom % 40;
                    3'd4:    v = $urandom % 6;
                    3'd5:    v = $urandom % 6;
                    default: v = $urandom;
                endcase
                wr(a, v);
            end else begin
                step();
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        #600000;
        if (!done) begin
            done = 1'b1;
            bad++;
            $display("FAIL watchdog in %s: actual hung expected finished", tag);
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

endmodule